// File: doc/BRIEF.md
# Fractional Audio Clock Generator

This block produces the two clocks that a serial audio port needs, both derived from one fast reference clock. The master clock comes from a divider whose ratio has a 16-bit integer part and a 16-bit fraction. A phase accumulator adds one extra reference cycle whenever the fraction carries over, so the long-run average ratio is exact. The bit clock comes from an integer divider that counts master-clock rising edges. Each output has a ready flag that software polls after it sets the matching enable.

All logic runs on the reference clock. Both outputs are registers that change only on reference edges. The block has no data stream. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure. The ratio word and the bit-clock divide field are read live while the block runs. A new value takes effect at the next half-period boundary.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is held, and after its release with both enables low, all four outputs are low.
- R2: The ratio word carries the fraction F in bits [31:16] and the integer W in bits [15:0]. Over the K master-clock periods that begin at the first rising edge after enable, the total length is K*W + floor(K*F/65536) reference cycles. The accumulator starts at zero on each enable.
- R3: The low phase lasts floor(W/2) reference cycles. The high phase lasts the rest of W plus any carry cycle. The first rising edge comes floor(W/2) cycles after the first reference edge that sees the enable high.
- R4: An integer field below 2 is treated as a ratio of exactly 2.0 with the fraction ignored, so the master clock never stops.
- R5: When master-clock enable is low, the master clock is low from the next reference edge and stays low.
- R6: Master-clock ready rises on the reference edge of the fourth master-clock transition after enable. It falls in the same cycle that the enable is cleared.
- R7: The bit-clock divide input N (bits [15:8] of the main configuration word, supplied as an 8-bit field) makes the bit clock toggle every N+1 master-clock rising edges. The bit-clock period is therefore 2*(N+1) master-clock periods.
- R8: Every bit-clock transition happens on the same reference edge as a master-clock rising edge.
- R9: Bit-clock ready rises on the fourth bit-clock transition after enable. It falls in the same cycle that master mode or master-clock enable is cleared. It is never high while master-clock ready is low.
- R10: With master mode set but master-clock enable low, the bit clock stays low and its ready flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mclk_en_i | input | 1 | Master-clock enable |
| master_en_i | input | 1 | Master mode: drive the bit clock |
| ratio_word_i | input | 32 | Fraction [31:16], integer [15:0] |
| bclk_div_i | input | 8 | Bit-clock divide field N |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| mclk_rdy_o | output | 1 | Master clock running and settled |
| bclk_rdy_o | output | 1 | Bit clock running and settled |

## Verification
A phase accumulator that is wrong or not cleared shows up at the ports as a carry cycle in the wrong period. The sum of a few consecutive master-clock periods then misses floor(K*F/65536) within K periods. A half-period counter that loads the wrong value shifts the first rising edge or the high/low split within one period. A miscounting bit-clock divider or edge counter moves the bit-clock period or the cycle where a ready flag rises, and both show within at most 4*(N+1) master-clock periods. An enable path that does not clear state shows as a clock or flag still high one reference cycle after its enable drops.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int unsigned WHOLE_W = 16;
  localparam int unsigned FRAC_W  = 16;
  localparam int unsigned BDIV_W  = 8;
  localparam int unsigned RDY_EDGES = 4;

  typedef struct packed {
    logic [FRAC_W-1:0]  frac;
    logic [WHOLE_W-1:0] whole;
  } ratio_word_t;
endpackage

// File: rtl/acg_frac_div.sv
module acg_frac_div #(
  parameter int unsigned WHOLE_W = 16,
  parameter int unsigned FRAC_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [WHOLE_W-1:0] whole_i,
  input  logic [FRAC_W-1:0]  frac_i,
  output logic               mclk_o,
  output logic               rise_o,
  output logic               toggle_o
);
  localparam logic [WHOLE_W-1:0] MIN_WHOLE = WHOLE_W'(2);
  localparam logic [WHOLE_W-1:0] ONE       = WHOLE_W'(1);

  logic               running_q;
  logic               level_q;
  logic [WHOLE_W-1:0] cnt_q;
  logic [FRAC_W-1:0]  acc_q;

  logic               too_small;
  logic [WHOLE_W-1:0] whole_eff;
  logic [FRAC_W-1:0]  frac_eff;
  logic [WHOLE_W-1:0] lo_len;
  logic [WHOLE_W-1:0] hi_base;
  logic [WHOLE_W-1:0] hi_len;
  logic [FRAC_W:0]    acc_sum;
  logic               carry;

  // clamp: a ratio below 2.0 becomes exactly 2.0
  always_comb begin
    too_small = (whole_i < MIN_WHOLE);
    whole_eff = too_small ? MIN_WHOLE : whole_i;
    frac_eff  = too_small ? '0 : frac_i;
    lo_len    = whole_eff >> 1;
    hi_base   = whole_eff - lo_len;
    acc_sum   = {1'b0, acc_q} + {1'b0, frac_eff};
    carry     = acc_sum[FRAC_W];
    hi_len    = hi_base + WHOLE_W'(carry);
  end

  assign toggle_o = running_q && en_i && (cnt_q == '0);
  assign rise_o   = toggle_o && !level_q;
  assign mclk_o   = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      level_q   <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
    end else if (!en_i) begin
      running_q <= 1'b0;
      level_q   <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
    end else if (!running_q) begin
      running_q <= 1'b1;
      level_q   <= 1'b0;
      cnt_q     <= lo_len - ONE;
      acc_q     <= '0;
    end else if (cnt_q == '0) begin
      level_q <= ~level_q;
      if (!level_q) begin
        cnt_q <= hi_len - ONE;
        acc_q <= acc_sum[FRAC_W-1:0];
      end else begin
        cnt_q <= lo_len - ONE;
      end
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  p_stop_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mclk_o);

  p_toggle_moves_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_o |=> (mclk_o != $past(mclk_o)));
endmodule

// File: rtl/acg_int_div.sv
module acg_int_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             toggle_o
);
  logic             level_q;
  logic [DIV_W-1:0] cnt_q;

  assign toggle_o = en_i && tick_i && (cnt_q == '0);
  assign bclk_o   = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en_i) begin
      level_q <= 1'b0;
      cnt_q   <= div_i;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        level_q <= ~level_q;
        cnt_q   <= div_i;
      end else begin
        cnt_q <= cnt_q - DIV_W'(1);
      end
    end
  end

  p_bclk_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (bclk_o != $past(bclk_o))) |-> $past(tick_i));
endmodule

// File: rtl/acg_ready.sv
module acg_ready #(
  parameter int unsigned EDGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_i,
  output logic rdy_o
);
  localparam int unsigned CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] TOP = CW'(EDGES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (edge_i && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign rdy_o = en_i && (cnt_q == TOP);

  p_rdy_late_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> $past(en_i));
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int unsigned RATIO_W = WHOLE_W + FRAC_W,
  parameter int unsigned DIV_W   = BDIV_W,
  parameter int unsigned EDGES   = RDY_EDGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mclk_en_i,
  input  logic               master_en_i,
  input  logic [RATIO_W-1:0] ratio_word_i,
  input  logic [DIV_W-1:0]   bclk_div_i,
  output logic               mclk_o,
  output logic               bclk_o,
  output logic               mclk_rdy_o,
  output logic               bclk_rdy_o
);
  localparam int unsigned NCLK = 2;

  ratio_word_t ratio;
  logic        mclk_rise;
  logic        mclk_tog;
  logic        bclk_tog;
  logic        bclk_en;
  logic [NCLK-1:0] rdy_en;
  logic [NCLK-1:0] rdy_edge;
  logic [NCLK-1:0] rdy_flag;

  assign ratio   = ratio_word_t'(ratio_word_i);
  assign bclk_en = master_en_i && mclk_en_i;

  acg_frac_div #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_mdiv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mclk_en_i),
    .whole_i  (ratio.whole),
    .frac_i   (ratio.frac),
    .mclk_o   (mclk_o),
    .rise_o   (mclk_rise),
    .toggle_o (mclk_tog)
  );

  acg_int_div #(.DIV_W(DIV_W)) u_bdiv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (bclk_en),
    .tick_i   (mclk_rise),
    .div_i    (bclk_div_i),
    .bclk_o   (bclk_o),
    .toggle_o (bclk_tog)
  );

  assign rdy_en   = {bclk_en, mclk_en_i};
  assign rdy_edge = {bclk_tog, mclk_tog};

  for (genvar g = 0; g < NCLK; g++) begin : g_rdy
    acg_ready #(.EDGES(EDGES)) u_rdy (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (rdy_en[g]),
      .edge_i (rdy_edge[g]),
      .rdy_o  (rdy_flag[g])
    );
  end

  assign mclk_rdy_o = rdy_flag[0];
  assign bclk_rdy_o = rdy_flag[1];

  p_bclk_under_mclk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rdy_o |-> mclk_rdy_o);

  p_bclk_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclk_en_i |=> !bclk_o);
endmodule

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mclk_en = 1'b0;
  logic        master_en = 1'b0;
  logic [31:0] ratio = 32'd0;
  logic [7:0]  bdiv = 8'd0;
  logic        mclk, bclk, mclk_rdy, bclk_rdy;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  audio_clkgen u0 (
    .clk_i(clk), .rst_ni(rst_n), .mclk_en_i(mclk_en), .master_en_i(master_en),
    .ratio_word_i(ratio), .bclk_div_i(bdiv),
    .mclk_o(mclk), .bclk_o(bclk), .mclk_rdy_o(mclk_rdy), .bclk_rdy_o(bclk_rdy)
  );

  localparam int NV = 8;
  localparam logic [15:0] T_WHOLE [NV] = '{16'd4, 16'd5, 16'd3, 16'd6, 16'd1, 16'd0, 16'd7, 16'd2};
  localparam logic [15:0] T_FRAC  [NV] = '{16'h0000, 16'h0000, 16'h8000, 16'h4000,
                                           16'h1234, 16'h0000, 16'hC000, 16'hFFFF};
  localparam int          T_K     [NV] = '{4, 4, 4, 8, 4, 4, 4, 4};
  localparam int          T_SUM   [NV] = '{16, 20, 14, 50, 8, 8, 31, 11};

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts negedge samples; returns index of first rise and cycles over K periods
  task automatic measure(input bit use_b, input int k, output int first, output int span,
                         output int misaligned);
    int n = 0, rises = 0, n0 = 0;
    logic prev = use_b ? bclk : mclk;
    logic mprev = mclk;
    first = -1; span = -1; misaligned = 0;
    for (int i = 0; i < 4000; i++) begin
      logic cur;
      @(negedge clk);
      n++;
      cur = use_b ? bclk : mclk;
      if (use_b && (cur != prev) && !(!mprev && mclk)) misaligned++;
      if (!prev && cur) begin
        rises++;
        if (rises == 1) begin first = n; n0 = n; end
        if (rises == k + 1) begin span = n - n0; break; end
      end
      prev = cur;
      mprev = mclk;
    end
  endtask

  task automatic quiesce();
    @(negedge clk);
    mclk_en = 1'b0; master_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first, span, mis, cnt, eff, tg;
    // R1 reset state
    repeat (4) @(negedge clk);
    chk("R1 mclk in reset", mclk, 0);
    chk("R1 bclk in reset", bclk, 0);
    chk("R1 mclk_rdy in reset", mclk_rdy, 0);
    chk("R1 bclk_rdy in reset", bclk_rdy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {mclk, bclk, mclk_rdy, bclk_rdy}, 0);

    // R2 R3 R4 vector table
    for (int v = 0; v < NV; v++) begin
      quiesce();
      ratio = {T_FRAC[v], T_WHOLE[v]};
      mclk_en = 1'b1;
      eff = (T_WHOLE[v] < 2) ? 2 : int'(T_WHOLE[v]);
      measure(1'b0, T_K[v], first, span, mis);
      chk($sformatf("R2/R4 span row %0d", v), span, T_SUM[v]);
      chk($sformatf("R3 first rise row %0d", v), first, eff / 2 + 1);
    end

    // R6 master ready timing, W=4: fourth transition at edge 8 after enable
    quiesce();
    ratio = 32'h0000_0004;
    mclk_en = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 mclk_rdy before 4th edge", mclk_rdy, 0);
    @(negedge clk);
    chk("R6 mclk_rdy at 4th edge", mclk_rdy, 1);
    mclk_en = 1'b0;
    #1;
    chk("R6 mclk_rdy drops with enable", mclk_rdy, 0);
    // R5 stop low
    @(negedge clk);
    chk("R5 mclk low after disable", mclk, 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mclk) cnt++;
    end
    chk("R5 mclk stays low", cnt, 0);

    // R3 duty, W=5: high 3, low 2
    quiesce();
    ratio = 32'h0000_0005;
    mclk_en = 1'b1;
    for (int i = 0; i < 50 && !mclk; i++) @(negedge clk);
    cnt = 0;
    while (mclk && cnt < 50) begin cnt++; @(negedge clk); end
    chk("R3 high phase W=5", cnt, 3);
    cnt = 0;
    while (!mclk && cnt < 50) begin cnt++; @(negedge clk); end
    chk("R3 low phase W=5", cnt, 2);

    // R7 R8 bit clock periods
    quiesce();
    ratio = 32'h0000_0002; bdiv = 8'd2;
    mclk_en = 1'b1; master_en = 1'b1;
    measure(1'b1, 2, first, span, mis);
    chk("R7 bclk span N=2 W=2", span, 24);
    chk("R8 bclk edges on mclk rise", mis, 0);

    quiesce();
    ratio = 32'h0000_0003; bdiv = 8'd5;
    mclk_en = 1'b1; master_en = 1'b1;
    measure(1'b1, 1, first, span, mis);
    chk("R7 bclk span N=5 W=3", span, 36);
    chk("R8 bclk edges on mclk rise N=5", mis, 0);

    quiesce();
    ratio = 32'h0000_0002; bdiv = 8'd0;
    mclk_en = 1'b1; master_en = 1'b1;
    measure(1'b1, 3, first, span, mis);
    chk("R7 bclk span N=0", span, 12);

    // R9 bit clock ready
    quiesce();
    ratio = 32'h0000_0002; bdiv = 8'd1;
    mclk_en = 1'b1; master_en = 1'b1;
    tg = 0;
    begin
      logic pb = bclk;
      for (int i = 0; i < 400 && tg < 4; i++) begin
        @(negedge clk);
        if (bclk != pb) begin
          tg++;
          if (tg == 3) chk("R9 bclk_rdy after 3 edges", bclk_rdy, 0);
          if (tg == 4) chk("R9 bclk_rdy after 4 edges", bclk_rdy, 1);
        end
        pb = bclk;
      end
    end
    chk("R9 four bclk edges seen", tg, 4);
    mclk_en = 1'b0;
    #1;
    chk("R9 bclk_rdy drops with mclk enable", bclk_rdy, 0);
    chk("R6 mclk_rdy drops too", mclk_rdy, 0);

    // R10 master mode without master clock
    quiesce();
    ratio = 32'h0000_0002; bdiv = 8'd0;
    master_en = 1'b1;
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclk || bclk_rdy || mclk) cnt++;
    end
    chk("R10 bclk idle without mclk", cnt, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule